// File: doc/BRIEF.md
# Protected System Clock Control Register

This block holds the eight control bits that steer a chip's clock generator. Software sets them through a single-cycle synchronous bus at one fixed address. The bits choose the clock output, whether the peripheral clock stops in wait mode, the sub-oscillator drive strength and port use, whether the main oscillator stops, the divide-by-8 setting and the system clock source. Each bit drives a decoded output. The oscillators, the PLL and the clock multiplexer are outside this block and are not modelled.

Two level inputs guard the register. A protect-enable input must be 1 for any bus write to land. A clock-modification lock input freezes the source-select, main-stop and wait-stop bits, while the other bits still accept writes.

Hardware keeps some bits safe no matter what software writes:
- The drive-strength bit is forced high whenever the sub-oscillator port bit is clear, and also on a stop-mode entry pulse.
- The divide-by-8 bit is forced high on stop-mode entry while the main (non-sub) clock is selected.
- The divide-by-8 bit is also held high while the on-chip oscillator is off and the main clock is stopped.

A read returns the register one cycle later and has no side effects.

Top module: `clkctl_reg`

## Requirements
- R1: Register bits map to outputs as follows: bits 1:0 to `clkout_sel`, bit 2 to `periph_stop_wait`, bit 3 to `sub_drive_hi`, bit 4 to `sub_port_en`, bit 5 to `main_stop`, bit 6 to `div8`, bit 7 to `sys_sub_sel` (1 selects the sub-clock).
- R2: Reset (`rst_n` low, asynchronous) loads 8'h48, which sets `div8` and `sub_drive_hi` only, and clears `rd_data`.
- R3: A write updates the register on the next rising edge only when `bus_wr` is 1, `bus_addr` equals `REG_ADDR`, and `wr_enable` is 1. Otherwise no bit changes except through the forcing of R5 to R7.
- R4: While `mod_lock` is 1, a write leaves bits 2, 5 and 7 unchanged and still updates bits 0, 1, 3, 4 and 6.
- R5: Bit 3 becomes 1 whenever the resulting bit 4 is 0, so a stored 0 in bit 4 always comes with a 1 in bit 3.
- R6: A `stop_entry` pulse forces bit 3 to 1. It also forces bit 6 to 1 when bit 7 is 0; when bit 7 is 1, bit 6 is left as it is.
- R7: While `osc_on` is 0 and the resulting bit 5 is 1, bit 6 is forced to 1, so a write of 0 to bit 6 has no effect.
- R8: Hardware forcing takes priority over a bus write in the same cycle.
- R9: When `bus_rd` is 1 and the address matches, `rd_data` shows the register value on the next edge; otherwise `rd_data` is 0. Reads never change the register.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| bus_addr | input | ADDR_W | Bus address |
| bus_wr | input | 1 | Write strobe |
| bus_rd | input | 1 | Read strobe |
| bus_wdata | input | 8 | Write data |
| wr_enable | input | 1 | Protect enable; writes land only when 1 |
| mod_lock | input | 1 | Clock-modification lock for bits 2, 5 and 7 |
| osc_on | input | 1 | On-chip oscillator enabled |
| stop_entry | input | 1 | One-cycle stop-mode entry pulse |
| clkout_sel | output | 2 | Clock output select |
| periph_stop_wait | output | 1 | Stop peripheral clock in wait mode |
| sub_drive_hi | output | 1 | Sub-oscillator high drive |
| sub_port_en | output | 1 | Sub-oscillator pins used for oscillation |
| main_stop | output | 1 | Main oscillator stop |
| div8 | output | 1 | Divide-by-8 (0: external divider field applies) |
| sys_sub_sel | output | 1 | System clock from sub-clock |
| rd_data | output | 8 | Registered read-back |

## Verification
The assertions check these every cycle:
- Locked bits stay stable.
- Unwritable bits hold when a write is not allowed.
- Bit 3 is always set whenever bit 4 is clear.
- Stop entry and the oscillator-off condition leave bit 6 set.
- Read-back matches the previous register value.

The bench's scenarios cover what the assertions cannot see:
- The merged value produced by a partial lock write.
- Stop entry that leaves bit 6 alone while the sub-clock is selected.
- A bus write colliding with forcing in the same cycle.
- Writes to the wrong address.
- Return to the reset value after a mid-run reset.

// File: rtl/clkctl_reg.sv
module clkctl_reg #(
  parameter int                ADDR_W    = 8,
  parameter logic [ADDR_W-1:0] REG_ADDR  = 'h06,
  parameter logic [7:0]        RESET_VAL = 8'h48,
  parameter logic [7:0]        LOCK_BITS = 8'hA4
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic              bus_rd,
  input  logic [7:0]        bus_wdata,
  input  logic              wr_enable,
  input  logic              mod_lock,
  input  logic              osc_on,
  input  logic              stop_entry,
  output logic [1:0]        clkout_sel,
  output logic              periph_stop_wait,
  output logic              sub_drive_hi,
  output logic              sub_port_en,
  output logic              main_stop,
  output logic              div8,
  output logic              sys_sub_sel,
  output logic [7:0]        rd_data
);

  logic [7:0] ctl, sw_val, nxt;
  logic       hit, wr_ok;
  logic [7:0] wmask;

  assign hit   = (bus_addr == REG_ADDR);
  assign wr_ok = bus_wr && hit && wr_enable;
  assign wmask = mod_lock ? ~LOCK_BITS : 8'hFF;

  assign sw_val = wr_ok ? ((bus_wdata & wmask) | (ctl & ~wmask)) : ctl;

  always_comb begin
    nxt = sw_val;
    if (!sw_val[4] || stop_entry)          nxt[3] = 1'b1;
    if (stop_entry && !ctl[7])             nxt[6] = 1'b1;
    if (!osc_on && sw_val[5])              nxt[6] = 1'b1;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      ctl     <= RESET_VAL;
      rd_data <= 8'h00;
    end else begin
      ctl     <= nxt;
      rd_data <= (bus_rd && hit) ? ctl : 8'h00;
    end
  end

  assign clkout_sel       = ctl[1:0];
  assign periph_stop_wait = ctl[2];
  assign sub_drive_hi     = ctl[3];
  assign sub_port_en      = ctl[4];
  assign main_stop        = ctl[5];
  assign div8             = ctl[6];
  assign sys_sub_sel      = ctl[7];

  assert_lock_hold_R4: assert property (@(posedge clk) disable iff (!rst_n)
    mod_lock |=> ($stable(ctl[7]) && $stable(ctl[5]) && $stable(ctl[2])));

  assert_no_write_hold_R3: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_wr && (bus_addr == REG_ADDR) && wr_enable) |=>
      ($stable(ctl[7]) && $stable(ctl[5]) && $stable(ctl[4]) && $stable(ctl[2:0])));

  assert_drive_forced_R5: assert property (@(posedge clk) disable iff (!rst_n)
    !sub_port_en |-> sub_drive_hi);

  assert_stop_force_R6: assert property (@(posedge clk) disable iff (!rst_n)
    (stop_entry && !sys_sub_sel) |=> (div8 && sub_drive_hi));

  assert_osc_hold_R7: assert property (@(posedge clk) disable iff (!rst_n)
    (main_stop && $past(!osc_on)) |-> div8);

  assert_readback_R9: assert property (@(posedge clk) disable iff (!rst_n)
    (bus_rd && bus_addr == REG_ADDR) |=> (rd_data == $past(ctl)));

  assert_read_idle_R9: assert property (@(posedge clk) disable iff (!rst_n)
    !(bus_rd && bus_addr == REG_ADDR) |=> (rd_data == 8'h00));

endmodule

// File: tb/clkctl_reg_tb.sv
module clkctl_reg_tb_top;
  localparam int ADDR_W = 8;
  localparam logic [ADDR_W-1:0] RA = 'h06;

  logic clk = 1'b0, rst_n = 1'b0;
  logic [ADDR_W-1:0] bus_addr = RA;
  logic bus_wr = 0, bus_rd = 0, wr_enable = 0, mod_lock = 0, osc_on = 1, stop_entry = 0;
  logic [7:0] bus_wdata = 0;
  logic [1:0] clkout_sel;
  logic periph_stop_wait, sub_drive_hi, sub_port_en, main_stop, div8, sys_sub_sel;
  logic [7:0] rd_data, obs;
  int checks = 0, errors = 0;
  bit done = 0;

  always #10 clk = ~clk;

  clkctl_reg #(.ADDR_W(ADDR_W), .REG_ADDR(RA)) dut_i (
    .clk, .rst_n, .bus_addr, .bus_wr, .bus_rd, .bus_wdata, .wr_enable, .mod_lock,
    .osc_on, .stop_entry, .clkout_sel, .periph_stop_wait, .sub_drive_hi,
    .sub_port_en, .main_stop, .div8, .sys_sub_sel, .rd_data);

  assign obs = {sys_sub_sel, div8, main_stop, sub_port_en, sub_drive_hi, periph_stop_wait, clkout_sel};

  // {wr, hit, protect, lock, osc_on, stop, wdata, expected}
  localparam int NV = 14;
  localparam logic [21:0] VEC [0:NV-1] = '{
    {6'b111010, 8'h00, 8'h08},  // R5 b4=0 forces b3
    {6'b111010, 8'h13, 8'h13},  // R3 plain write
    {6'b110010, 8'hFF, 8'h13},  // R3 protect off
    {6'b111110, 8'hFF, 8'h5B},  // R4 lock merge
    {6'b111010, 8'hA4, 8'hAC},  // R5 sub select
    {6'b000011, 8'h00, 8'hAC},  // R6 stop with b7=1 leaves b6
    {6'b111000, 8'h30, 8'h70},  // R7 osc off + b5
    {6'b111000, 8'h10, 8'h10},  // R7 b5 cleared: no hold
    {6'b111000, 8'h30, 8'h70},  // R7 again
    {6'b111000, 8'h20, 8'h68},  // R7 write 0 to b6 ignored
    {6'b111010, 8'h10, 8'h10},  // R3 clear
    {6'b000011, 8'h00, 8'h58},  // R6 stop from main
    {6'b111011, 8'h10, 8'h58},  // R8 forcing beats write
    {6'b101010, 8'h13, 8'h58}   // R3 wrong address
  };

  task automatic check(input string req, input logic [7:0] act, input logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      errors++;
      $display("FAIL %s actual=%02h expected=%02h", req, act, exp);
    end
  endtask

  task automatic do_read(input logic [ADDR_W-1:0] a, input logic [7:0] exp, input string req);
    @(negedge clk); bus_addr = a; bus_rd = 1;
    @(negedge clk); bus_rd = 0; bus_addr = RA;
    check(req, rd_data, exp);
  endtask

  initial begin
    #(20 * 50000);
    if (!done) begin
      errors++; checks++;
      $display("FAIL watchdog expired");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin
    repeat (3) @(negedge clk);
    check("R2 reset value", obs, 8'h48);
    check("R2 rd_data reset", rd_data, 8'h00);
    rst_n = 1;
    @(negedge clk);
    check("R1 outputs after reset", {sys_sub_sel, div8, main_stop, sub_port_en,
          sub_drive_hi, periph_stop_wait, clkout_sel}, 8'h48);
    for (int i = 0; i < NV; i++) begin
      @(negedge clk);
      bus_wr = VEC[i][21]; bus_addr = VEC[i][20] ? RA : RA + 1'b1;
      wr_enable = VEC[i][19]; mod_lock = VEC[i][18]; osc_on = VEC[i][17];
      stop_entry = VEC[i][16]; bus_wdata = VEC[i][15:8];
      @(negedge clk);
      bus_wr = 0; stop_entry = 0; mod_lock = 0; bus_addr = RA;
      check($sformatf("R1/R3-R8 vector %0d", i), obs, VEC[i][7:0]);
      do_read(RA, VEC[i][7:0], $sformatf("R9 readback vector %0d", i));
    end
    do_read(RA + 1'b1, 8'h00, "R9 wrong address read");
    check("R9 read no side effect", obs, 8'h58);
    @(negedge clk); rst_n = 0;
    @(negedge clk);
    check("R2 mid-run reset", obs, 8'h48);
    rst_n = 1;
    done = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule